// File: doc/BRIEF.md
# Buffered Two-Cycle DMA Data Mover

This block moves a run of bytes for one DMA channel through a four-byte staging buffer. It never drives source and destination in the same bus cycle. Each chunk is first read from the source into the buffer, then written from the buffer to the destination. The source and destination ports are each 8 or 16 bits wide. That mix, together with the bytes still left to move, decides how many bus cycles a chunk costs.

A channel is described by two base addresses: a requester address and a target address. It also has a byte count, a width flag for each side, and a direction flag that picks which side is read. A one-cycle start launches the run. The block then issues read and write requests one at a time. Each request holds until the bus acknowledges it. The block raises a single-cycle completion pulse when the last byte has been written.

Top module: `dma_mover`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_rd`, `bus_wr` and `done` are all low.
- R2: With `dir` = 0 the requester side is read and the target side is written. With `dir` = 1 the target side is read and the requester side is written. A side's width flag (1 = 16-bit, 0 = 8-bit) applies to that side whichever role it plays.
- R3: Each beat moves 1 or 2 bytes. On a 16-bit port a beat is 2 bytes (`bus_pair` = 1) while at least two bytes of the current chunk remain for that phase; otherwise it is 1 byte. An 8-bit port always moves 1 byte. In a 2-byte beat, data bits [7:0] belong to the lower address and bits [15:8] to the next address. A 1-byte beat uses bits [7:0], and `bus_wdata[15:8]` is zero.
- R4: A chunk is min(4, bytes remaining). All of a chunk is read before its first write. The buffer is empty before the next chunk's first read. Reads and writes are never requested together, and the buffer never holds more than four bytes.
- R5: The first read is at the source base and the first write is at the destination base. Each address advances by the number of bytes its beat moved.
- R6: The destination receives exactly the source bytes, in address order.
- R7: A request keeps its kind, address, size and write data until the cycle `bus_ack` is sampled high. The following request is presented only after that.
- R8: One cycle after the last write is acknowledged, `done` is high for exactly one cycle and `busy` is low. A start with a zero count gives the same `done` pulse without any bus request.
- R9: A start pulse while the block is busy is ignored: the running transfer continues unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transfer (taken only when idle) |
| dir | input | 1 | 0: requester is source; 1: target is source |
| cnt | input | CW | Number of bytes to move |
| req_base | input | AW | Requester-side start address |
| tgt_base | input | AW | Target-side start address |
| req_wide | input | 1 | Requester port is 16-bit |
| tgt_wide | input | 1 | Target port is 16-bit |
| bus_rd | output | 1 | Read request toward the source |
| bus_wr | output | 1 | Write request toward the destination |
| bus_addr | output | AW | Byte address of the current request |
| bus_pair | output | 1 | Current beat moves two bytes |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken when acknowledged |
| bus_ack | input | 1 | Completes the current request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Odd tails on a 16-bit port.** A wrong design issues a 2-byte beat past the end of the chunk and corrupts or overruns the destination.
- **Runs shorter than four bytes.** A design that always fills four bytes reads beyond the source.
- **Mixed widths in both directions.** Swapped roles or widths show up as wrong beat sizes or wrong addresses.
- **Zero count.** A mishandled zero count hangs or issues spurious requests.
- **Delayed acknowledges.** A design that changes its request before the acknowledge shows up here.
- **Start pulse mid-run.** A design that honours it restarts the run or tails on a second one.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_FILL  = 2'd1,
    MV_DRAIN = 2'd2
  } mv_state_e;

  // a beat takes two bytes only on a wide port with two bytes still owed
  function automatic logic beat_is_pair(input logic wide, input int unsigned left);
    return wide && (left >= 2);
  endfunction

  // bytes staged by one chunk
  function automatic int unsigned chunk_goal(input int unsigned remaining,
                                             input int unsigned depth);
    return (remaining < depth) ? remaining : depth;
  endfunction

endpackage

// File: rtl/dma_mover_ptr.sv
module dma_mover_ptr #(
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          pair,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= addr_q + (pair ? AW'(2) : AW'(1));
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_mover_buf.sv
module dma_mover_buf #(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_pair,
  input  logic [IW-1:0] wr_idx,
  input  logic [15:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_data
);
  logic [7:0]       slot_q [DEPTH];
  logic [DEPTH-1:0] hit_lo;
  logic [DEPTH-1:0] hit_hi;
  logic [IW-1:0]    wr_next;
  logic [IW-1:0]    rd_next;

  assign wr_next = wr_idx + IW'(1);
  assign rd_next = rd_idx + IW'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    assign hit_lo[g] = wr_en && (wr_idx == IW'(g));
    assign hit_hi[g] = wr_en && wr_pair && (wr_next == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit_lo[i])      slot_q[i] <= wr_data[7:0];
        else if (hit_hi[i]) slot_q[i] <= wr_data[15:8];
      end
    end
  end

  assign rd_data = {slot_q[rd_next], slot_q[rd_idx]};
endmodule

// File: rtl/dma_mover_seq.sv
module dma_mover_seq
  import dma_mover_pkg::*;
#(
  parameter int CW    = 24,
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int BW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt,
  input  logic          src_wide,
  input  logic          dst_wide,
  input  logic          bus_ack,
  output mv_state_e     state,
  output logic          rd_beat,
  output logic          wr_beat,
  output logic          pair,
  output logic [IW-1:0] fill_idx,
  output logic [IW-1:0] drain_idx,
  output logic          done
);
  mv_state_e     state_q;
  logic [BW-1:0] goal_q, filled_q, drained_q;
  logic [CW-1:0] remain_q;
  logic          src_wide_q, dst_wide_q, done_q;
  logic [BW-1:0] fill_left, drain_left, step;
  logic [CW-1:0] remain_nx;
  logic          chunk_in, chunk_out, last_out;

  assign fill_left  = goal_q - filled_q;
  assign drain_left = goal_q - drained_q;

  always_comb begin
    case (state_q)
      MV_FILL:  pair = beat_is_pair(src_wide_q, 32'(fill_left));
      MV_DRAIN: pair = beat_is_pair(dst_wide_q, 32'(drain_left));
      default:  pair = 1'b0;
    endcase
  end

  assign step      = pair ? BW'(2) : BW'(1);
  assign rd_beat   = (state_q == MV_FILL) && bus_ack;
  assign wr_beat   = (state_q == MV_DRAIN) && bus_ack;
  assign chunk_in  = rd_beat && ((filled_q + step) == goal_q);
  assign chunk_out = wr_beat && ((drained_q + step) == goal_q);
  assign remain_nx = remain_q - CW'(step);
  assign last_out  = chunk_out && (remain_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MV_IDLE;
      goal_q     <= '0;
      filled_q   <= '0;
      drained_q  <= '0;
      remain_q   <= '0;
      src_wide_q <= 1'b0;
      dst_wide_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        MV_IDLE: if (start) begin
          src_wide_q <= src_wide;
          dst_wide_q <= dst_wide;
          if (cnt == '0) begin
            done_q <= 1'b1;
          end else begin
            remain_q  <= cnt;
            goal_q    <= BW'(chunk_goal(32'(cnt), DEPTH));
            filled_q  <= '0;
            drained_q <= '0;
            state_q   <= MV_FILL;
          end
        end
        MV_FILL: if (rd_beat) begin
          filled_q <= filled_q + step;
          if (chunk_in) state_q <= MV_DRAIN;
        end
        MV_DRAIN: if (wr_beat) begin
          drained_q <= drained_q + step;
          remain_q  <= remain_nx;
          if (last_out) begin
            state_q <= MV_IDLE;
            done_q  <= 1'b1;
          end else if (chunk_out) begin
            goal_q    <= BW'(chunk_goal(32'(remain_nx), DEPTH));
            filled_q  <= '0;
            drained_q <= '0;
            state_q   <= MV_FILL;
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign fill_idx  = filled_q[IW-1:0];
  assign drain_idx = drained_q[IW-1:0];
  assign done      = done_q;
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_mover_pkg::*;
#(
  parameter int AW    = 26,
  parameter int CW    = 24,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] tgt_base,
  input  logic          req_wide,
  input  logic          tgt_wide,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_pair,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  output logic          done
);
  localparam int IW = $clog2(DEPTH);

  mv_state_e     state;
  logic          rd_beat, wr_beat, pair, take;
  logic [IW-1:0] fill_idx, drain_idx;
  logic [AW-1:0] src_addr, dst_addr;
  logic [15:0]   stage_out;

  assign take = start && (state == MV_IDLE);

  dma_mover_seq #(.CW(CW), .DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cnt      (cnt),
    .src_wide (dir ? tgt_wide : req_wide),
    .dst_wide (dir ? req_wide : tgt_wide),
    .bus_ack  (bus_ack),
    .state    (state),
    .rd_beat  (rd_beat),
    .wr_beat  (wr_beat),
    .pair     (pair),
    .fill_idx (fill_idx),
    .drain_idx(drain_idx),
    .done     (done)
  );

  dma_mover_ptr #(.AW(AW)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .load_val(dir ? tgt_base : req_base),
    .step    (rd_beat),
    .pair    (pair),
    .addr    (src_addr)
  );

  dma_mover_ptr #(.AW(AW)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .load_val(dir ? req_base : tgt_base),
    .step    (wr_beat),
    .pair    (pair),
    .addr    (dst_addr)
  );

  dma_mover_buf #(.DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rd_beat),
    .wr_pair(pair),
    .wr_idx (fill_idx),
    .wr_data(bus_rdata),
    .rd_idx (drain_idx),
    .rd_data(stage_out)
  );

  assign bus_rd    = (state == MV_FILL);
  assign bus_wr    = (state == MV_DRAIN);
  assign bus_addr  = bus_rd ? src_addr : dst_addr;
  assign bus_pair  = pair;
  assign bus_wdata = pair ? stage_out : {8'h00, stage_out[7:0]};
  assign busy      = (state != MV_IDLE);
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int AW    = 26,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          bus_pair,
  input logic [15:0]   bus_wdata,
  input logic          bus_ack,
  input logic          busy,
  input logic          done
);
  // bytes staged, tracked from the bus side only
  logic [3:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (bus_ack && bus_rd) held <= held + (bus_pair ? 4'd2 : 4'd1);
    else if (bus_ack && bus_wr) held <= held - (bus_pair ? 4'd2 : 4'd1);
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 4'(DEPTH));
  // R4
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !$past(bus_rd)) |-> (held == 4'd0));
  // R4
  wr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (held != 4'd0));
  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr) && $stable(bus_pair)));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_pair)
                              && $stable(bus_wdata)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_rd && !bus_wr));
endmodule

bind dma_mover dma_mover_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_pair (bus_pair),
  .bus_wdata(bus_wdata),
  .bus_ack  (bus_ack),
  .busy     (busy),
  .done     (done)
);

// File: tb/dma_mover_tb.sv
`timescale 1ns/1ps
module dma_mover_tb;
  localparam int AW = 26;
  localparam int CW = 24;

  typedef struct packed {
    logic          wr;
    logic          pair;
    logic [AW-1:0] addr;
  } op_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          dir = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [AW-1:0] req_base = '0;
  logic [AW-1:0] tgt_base = '0;
  logic          req_wide = 1'b0;
  logic          tgt_wide = 1'b0;
  logic          bus_rd, bus_wr, bus_pair, busy, done;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic          bus_ack = 1'b0;

  int  n_chk = 0;
  int  n_bad = 0;
  int  ack_delay = 0;
  bit  finished = 0;
  op_t exp_q[$];
  logic [7:0] mem [0:1023];

  always #2 clk = ~clk;

  dma_mover #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .cnt(cnt),
    .req_base(req_base), .tgt_base(tgt_base), .req_wide(req_wide),
    .tgt_wide(tgt_wide), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_pair(bus_pair), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor and bus responder: pops the expected op at its first appearance
  initial begin
    int  waitc = 0;
    bit  seen = 0;
    op_t e;
    forever begin
      @(negedge clk);
      bus_ack = 1'b0;
      if (bus_rd || bus_wr) begin
        if (!seen) begin
          seen = 1;
          if (exp_q.size() == 0) begin
            check(0, "R7", "unexpected request", int'(bus_addr), -1);
          end else begin
            e = exp_q.pop_front();
            check(bus_wr == e.wr, "R4", "request kind (1=write)", int'(bus_wr), int'(e.wr));
            check(bus_pair == e.pair, "R3", "beat is two bytes", int'(bus_pair), int'(e.pair));
            check(bus_addr == e.addr, "R5", "request address", int'(bus_addr), int'(e.addr));
          end
        end
        if (waitc == ack_delay) begin
          if (bus_rd)
            bus_rdata = bus_pair ? {mem[bus_addr[9:0] + 10'd1], mem[bus_addr[9:0]]}
                                 : {8'h00, mem[bus_addr[9:0]]};
          else begin
            mem[bus_addr[9:0]] = bus_wdata[7:0];
            if (bus_pair) mem[bus_addr[9:0] + 10'd1] = bus_wdata[15:8];
            else check(bus_wdata[15:8] == 8'h00, "R3", "idle upper lane", int'(bus_wdata[15:8]), 0);
          end
          bus_ack = 1'b1;
          waitc = 0;
          seen = 0;
        end else begin
          waitc++;
        end
      end
    end
  end

  // driver: restates the chunk and beat rules, queues expected ops, runs one move
  task automatic run_xfer(input bit d, input int rb, input int tb, input int n,
                          input bit rw, input bit tw, input int dly, input bit poke);
    int src = d ? tb : rb;
    int dst = d ? rb : tb;
    bit sw  = d ? tw : rw;
    bit dw  = d ? rw : tw;
    int left = n;
    int s = src;
    int t = dst;
    logic [7:0] want [$];
    bit got_done = 0;
    for (int i = 0; i < n; i++) want.push_back(mem[src + i]);
    while (left > 0) begin
      int chunk = (left < 4) ? left : 4;
      int k = 0;
      while (k < chunk) begin
        bit p = sw && (chunk - k >= 2);
        exp_q.push_back('{wr: 1'b0, pair: p, addr: AW'(s)});
        s += p ? 2 : 1;
        k += p ? 2 : 1;
      end
      k = 0;
      while (k < chunk) begin
        bit p = dw && (chunk - k >= 2);
        exp_q.push_back('{wr: 1'b1, pair: p, addr: AW'(t)});
        t += p ? 2 : 1;
        k += p ? 2 : 1;
      end
      left -= chunk;
    end
    ack_delay = dly;
    @(negedge clk);
    dir = d; req_base = AW'(rb); tgt_base = AW'(tb); cnt = CW'(n);
    req_wide = rw; tgt_wide = tw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000 && !got_done; c++) begin
      if (done) got_done = 1;
      else begin
        if (poke && c == 3) begin
          // R9: a second launch while busy, with other parameters
          dir = ~d; cnt = CW'(7); req_base = AW'(900); tgt_base = AW'(950); start = 1'b1;
        end else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    check(got_done, "R8", "done seen", int'(got_done), 1);
    check(!busy, "R8", "busy with done", int'(busy), 0);
    check(exp_q.size() == 0, "R4", "ops left unissued", exp_q.size(), 0);
    for (int i = 0; i < n; i++)
      check(mem[dst + i] == want[i], "R6", "destination byte (R2 roles)",
            int'(mem[dst + i]), int'(want[i]));
    @(negedge clk);
    check(!done, "R8", "done width", int'(done), 0);
    check(!busy && !bus_rd && !bus_wr, poke ? "R9" : "R8", "idle after done",
          int'(busy), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + 5);
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !bus_rd && !bus_wr && !done, "R1", "reset outputs",
          int'({busy, bus_rd, bus_wr, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !bus_rd && !bus_wr && !done, "R1", "idle after reset",
          int'({busy, bus_rd, bus_wr, done}), 0);
    run_xfer(0, 100, 600, 5, 0, 0, 0, 0);  // 8 -> 8
    run_xfer(0, 120, 620, 9, 1, 1, 0, 0);  // 16 -> 16, odd tail
    run_xfer(0, 140, 640, 6, 0, 1, 1, 0);  // 8 -> 16
    run_xfer(1, 660, 160, 7, 0, 1, 0, 0);  // R2: target is the 16-bit source
    run_xfer(0, 181, 681, 3, 1, 1, 0, 0);  // short chunk below four
    run_xfer(0, 200, 700, 0, 1, 0, 0, 0);  // R8 zero count
    run_xfer(1, 720, 220, 1, 1, 1, 0, 0);  // single byte on wide ports
    run_xfer(0, 240, 740, 10, 1, 0, 2, 1); // slow acks plus ignored start
    finish_run();
  end
endmodule